// File: doc/BRIEF.md
# Dual-Slot Ethernet Frame Receive Buffer

This block sits after a MAC receive path and before the host bus. It takes a byte stream of received frames and writes each frame into one of two on-chip receive slots. The slots are filled in strict alternation. Bytes are packed into 32-bit words, least significant byte first, starting at the first word of the slot. The 4-byte frame check sequence is stored together with the rest of the frame.

Each slot has a status word. That word holds a done flag, which the hardware sets, and an interrupt enable, which the host sets. When a frame lands in a slot, the done flag of that slot rises and the write pointer moves to the other slot. The host reads the frame over a simple register bus and then clears done to hand the slot back.

If the slot due next still holds an unacknowledged frame, the incoming frame is discarded whole. The pointer then stays on that slot. A frame too long to fit a slot is also discarded.

The stream input uses valid/ready. A beat is taken on any clock edge where both `rx_valid` and `rx_ready` are high. `rx_ready` is low only during reset and for the first edge after reset. After that it stays high, so the block never holds the MAC back. Frames that cannot be stored are absorbed and dropped instead of being stalled. The source may hold `rx_valid` low between beats. `rx_last` marks the final byte of a frame.

Top module: `eth_rx_pingpong`

## Requirements
- R1: `rx_ready` is low while reset is asserted. From the second clock edge after reset release it stays high, so a beat is accepted on every edge where `rx_valid` is high.
- R2: Byte k of a stored frame (counting from 0) lands in word k/4 of its slot, at bits [8*(k%4)+7 : 8*(k%4)]. The unused upper bytes of a partial final word read as zero. Word 0 of slot A is at byte address 0x1000 and word 0 of slot B is at 0x1800.
- R3: When the last byte of a stored frame is accepted, bit 0 (done) of that slot's status word reads 1 from the following cycle.
- R4: The first stored frame after reset goes to slot A. Each stored frame moves the target to the other slot.
- R5: A frame whose first byte arrives while the target slot has done = 1 is discarded entirely. The slot's contents and status stay unchanged, and the next frame targets the same slot.
- R6: A host write to a status word does two things. If bit 0 of the written data is 0, done clears. Bit 3 of the written data is stored as the interrupt enable. Writing 1 to bit 0 never sets done. All status bits other than 0 and 3 read as zero.
- R7: `irq` is high exactly when some slot has both done = 1 and interrupt enable = 1.
- R8: Each status word is the last word of its 2 KB slot, at 0x17FC for slot A and 0x1FFC for slot B. Host writes to data words have no effect. Reads below 0x1000 return 0.
- R9: A frame longer than 2044 bytes (the slot minus its status word) is discarded. Done is not set and the target slot does not change.
- R10: A host read presents its data on `bus_rdata` one cycle after `bus_rd`. After reset, both status words read 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Block can accept a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the frame |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 13 | Host byte address (bits 1:0 ignored) |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, registered |
| irq | output | 1 | Receive interrupt |

## Verification
The bound checker watches the rules that hold on every cycle. It checks that no word is written into a slot whose done flag is set, and that the status word is never overwritten by frame data. It checks that done only rises because a frame completed on a last beat, and that a host clear always takes effect. It also checks that the target moves to the other slot after each stored frame, and that the interrupt enable changes only on a status write. Byte ordering, zero padding of the final word, the retry of the same slot after a discard, the length limit, and how the address map is laid out are checked only by the bench scenarios, which read the frames back over the bus.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int STAT_DONE_BIT = 0;
  localparam int STAT_IE_BIT = 3;

  typedef struct packed {
    logic ie;
    logic done;
  } slot_stat_t;

  function automatic logic [31:0] pack_status(slot_stat_t s);
    logic [31:0] w;
    w = '0;
    w[STAT_DONE_BIT] = s.done;
    w[STAT_IE_BIT] = s.ie;
    return w;
  endfunction
endpackage

// File: rtl/rx_word_packer.sv
module rx_word_packer #(
  parameter int BUF_WORDS = 512,
  localparam int IDX_W = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic [7:0]       beat_data,
  input  logic             beat_last,
  input  logic [1:0]       slot_full,
  output logic             wr_en,
  output logic             wr_slot,
  output logic [IDX_W-1:0] wr_idx,
  output logic [31:0]      wr_data,
  output logic             fill_pulse,
  output logic             fill_slot,
  output logic             cur_slot
);
  localparam logic [IDX_W-1:0] CAP_IDX = IDX_W'(BUF_WORDS - 1);

  logic             in_frame_q, drop_q, cur_q;
  logic [IDX_W-1:0] wptr_q;
  logic [1:0]       lane_q;
  logic [31:0]      acc_q, acc_nxt;
  logic             drop_now, at_cap, drop_this, word_end;

  always_comb begin
    drop_now  = in_frame_q ? drop_q : slot_full[cur_q];
    at_cap    = (wptr_q == CAP_IDX);
    drop_this = drop_now | at_cap;
    acc_nxt   = ((lane_q == 2'd0) ? 32'd0 : acc_q) | (32'(beat_data) << {lane_q, 3'b000});
    word_end  = (lane_q == 2'd3) | beat_last;
  end

  assign wr_en      = beat & word_end & ~drop_this;
  assign wr_slot    = cur_q;
  assign wr_idx     = wptr_q;
  assign wr_data    = acc_nxt;
  assign fill_pulse = beat & beat_last & ~drop_this;
  assign fill_slot  = cur_q;
  assign cur_slot   = cur_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      drop_q     <= 1'b0;
      cur_q      <= 1'b0;
      wptr_q     <= '0;
      lane_q     <= '0;
      acc_q      <= '0;
    end else if (beat) begin
      if (beat_last) begin
        in_frame_q <= 1'b0;
        drop_q     <= 1'b0;
        wptr_q     <= '0;
        lane_q     <= '0;
        if (!drop_this) cur_q <= ~cur_q;
      end else begin
        in_frame_q <= 1'b1;
        drop_q     <= drop_this;
        lane_q     <= lane_q + 2'd1;
        acc_q      <= acc_nxt;
        if (lane_q == 2'd3 && !at_cap) wptr_q <= wptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_slot_mem.sv
module rx_slot_mem #(
  parameter int BUF_WORDS = 512,
  localparam int IDX_W = $clog2(BUF_WORDS)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic             wr_slot,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_data,
  input  logic             rd_slot,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);
  logic [31:0] bank_q [eth_rx_pkg::NUM_SLOTS];

  for (genvar s = 0; s < eth_rx_pkg::NUM_SLOTS; s++) begin : g_bank
    logic [31:0] store [BUF_WORDS];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == 1'(s))) store[wr_idx] <= wr_data;
    end
    assign bank_q[s] = store[rd_idx];
  end

  assign rd_word = bank_q[rd_slot];
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import eth_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fill_pulse,
  input  logic        fill_slot,
  input  logic        stat_wr,
  input  logic        stat_slot,
  input  logic [31:0] stat_wdata,
  output logic [1:0]  done,
  output logic [1:0]  ie,
  output logic        irq
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_stat
    slot_stat_t st_q;
    logic hw_set, host_hit;
    assign hw_set   = fill_pulse && (fill_slot == 1'(s));
    assign host_hit = stat_wr && (stat_slot == 1'(s));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= '0;
      end else begin
        if (hw_set) st_q.done <= 1'b1;
        else if (host_hit && !stat_wdata[STAT_DONE_BIT]) st_q.done <= 1'b0;
        if (host_hit) st_q.ie <= stat_wdata[STAT_IE_BIT];
      end
    end
    assign done[s] = st_q.done;
    assign ie[s]   = st_q.ie;
  end

  assign irq = |(done & ie);
endmodule

// File: rtl/eth_rx_pingpong.sv
module eth_rx_pingpong
  import eth_rx_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rx_valid,
  output logic                           rx_ready,
  input  logic [7:0]                     rx_data,
  input  logic                           rx_last,
  input  logic                           bus_rd,
  input  logic                           bus_wr,
  input  logic [$clog2(BUF_WORDS)+3:0]   bus_addr,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           irq
);
  localparam int IDX_W = $clog2(BUF_WORDS);
  localparam int REGION_BIT = IDX_W + 3;
  localparam int SLOT_BIT = IDX_W + 2;
  localparam logic [IDX_W-1:0] STAT_IDX = IDX_W'(BUF_WORDS - 1);

  logic             ready_q;
  logic             beat;
  logic             wr_en, wr_slot, fill_pulse, fill_slot, cur_slot;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      wr_data, rd_word;
  logic [1:0]       done, ie;
  logic             in_region, a_slot, is_stat, stat_wr;
  logic [IDX_W-1:0] a_idx;
  slot_stat_t       sel_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign rx_ready = ready_q;
  assign beat     = rx_valid & ready_q;

  assign in_region = bus_addr[REGION_BIT];
  assign a_slot    = bus_addr[SLOT_BIT];
  assign a_idx     = bus_addr[IDX_W+1:2];
  assign is_stat   = in_region && (a_idx == STAT_IDX);
  assign stat_wr   = bus_wr && is_stat;

  rx_word_packer #(.BUF_WORDS(BUF_WORDS)) u_pack (
    .clk(clk), .rst_n(rst_n), .beat(beat), .beat_data(rx_data),
    .beat_last(rx_last), .slot_full(done), .wr_en(wr_en),
    .wr_slot(wr_slot), .wr_idx(wr_idx), .wr_data(wr_data),
    .fill_pulse(fill_pulse), .fill_slot(fill_slot), .cur_slot(cur_slot)
  );

  rx_slot_mem #(.BUF_WORDS(BUF_WORDS)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_slot(a_slot), .rd_idx(a_idx), .rd_word(rd_word)
  );

  rx_status_regs u_stat (
    .clk(clk), .rst_n(rst_n), .fill_pulse(fill_pulse), .fill_slot(fill_slot),
    .stat_wr(stat_wr), .stat_slot(a_slot), .stat_wdata(bus_wdata),
    .done(done), .ie(ie), .irq(irq)
  );

  always_comb begin
    sel_stat.done = done[a_slot];
    sel_stat.ie   = ie[a_slot];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (!in_region)   bus_rdata <= '0;
      else if (is_stat) bus_rdata <= pack_status(sel_stat);
      else              bus_rdata <= rd_word;
    end
  end
endmodule

// File: rtl/eth_rx_pingpong_chk.sv
module eth_rx_pingpong_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_ready,
  input logic             rx_valid,
  input logic             rx_last,
  input logic             wr_en,
  input logic             wr_slot,
  input logic [IDX_W-1:0] wr_idx,
  input logic             fill_pulse,
  input logic             fill_slot,
  input logic             cur_slot,
  input logic [1:0]       done,
  input logic [1:0]       ie,
  input logic             irq,
  input logic             stat_wr,
  input logic             stat_slot,
  input logic             stat_bit0
);
  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  a_r1_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rx_ready);

  a_r3_fill_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pulse |-> (rx_valid && rx_ready && rx_last));

  a_r3_done0_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[0]) |-> $past(fill_pulse && !fill_slot));

  a_r3_done1_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done[1]) |-> $past(fill_pulse && fill_slot));

  a_r4_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    fill_pulse |=> (cur_slot != $past(fill_slot)));

  a_r5_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !done[wr_slot]);

  a_r8_status_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != LAST_IDX));

  a_r6_clear_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_bit0 && !(fill_pulse && fill_slot == stat_slot))
      |=> !done[$past(stat_slot)]);

  a_r6_ie_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> $stable(ie));

  a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done != 2'b00));
endmodule

bind eth_rx_pingpong eth_rx_pingpong_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .rx_valid(rx_valid),
  .rx_last(rx_last), .wr_en(wr_en), .wr_slot(wr_slot), .wr_idx(wr_idx),
  .fill_pulse(fill_pulse), .fill_slot(fill_slot), .cur_slot(cur_slot),
  .done(done), .ie(ie), .irq(irq), .stat_wr(stat_wr), .stat_slot(a_slot),
  .stat_bit0(bus_wdata[0])
);

// File: tb/sim_eth_rx_pingpong.sv
module sim_eth_rx_pingpong;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] A_BASE = 13'h1000;
  localparam logic [12:0] B_BASE = 13'h1800;
  localparam logic [12:0] A_STAT = 13'h17FC;
  localparam logic [12:0] B_STAT = 13'h1FFC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] rx_data = '0;
  logic [12:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic rx_ready, irq;
  logic [31:0] bus_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_rx_pingpong u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(logic [7:0] seed, int len, int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 4; b++)
      if (4*w + b < len) v[8*b +: 8] = seed + 8'(4*w + b);
    return v;
  endfunction

  task automatic send_frame(int len, logic [7:0] seed);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = seed + 8'(k);
      rx_last  = (k == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic host_rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic host_wr(logic [12:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 ready low in reset", 32'(rx_ready), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 ready after reset", 32'(rx_ready), 32'd1);
    host_rd(A_STAT, d); check("R10 slot A status reset", d, 32'd0);
    host_rd(B_STAT, d); check("R10 slot B status reset", d, 32'd0);
    check("R10 irq reset", 32'(irq), 32'd0);
  endtask

  task automatic t_first_two();
    logic [31:0] d;
    send_frame(10, 8'h10);
    for (int w = 0; w < 3; w++) begin
      host_rd(A_BASE + 13'(4*w), d);
      check("R2 slot A packing/pad", d, exp_word(8'h10, 10, w));
    end
    host_rd(A_STAT, d); check("R3 slot A done", d, 32'h1);
    host_rd(B_STAT, d); check("R4 slot B idle after first", d, 32'h0);
    send_frame(7, 8'h80);
    host_rd(B_BASE, d);      check("R4 second frame in slot B w0", d, exp_word(8'h80, 7, 0));
    host_rd(B_BASE + 4, d);  check("R2 slot B pad", d, exp_word(8'h80, 7, 1));
    host_rd(B_STAT, d);      check("R3 slot B done", d, 32'h1);
  endtask

  task automatic t_drop_retry();
    logic [31:0] d;
    send_frame(5, 8'hC0);
    host_rd(A_BASE, d); check("R5 full slot A untouched", d, exp_word(8'h10, 10, 0));
    host_rd(B_BASE, d); check("R5 full slot B untouched", d, exp_word(8'h80, 7, 0));
    host_wr(A_STAT, 32'h0);
    host_rd(A_STAT, d); check("R6 done cleared", d, 32'h0);
    send_frame(4, 8'h40);
    host_rd(A_BASE, d); check("R5 retry goes to slot A", d, exp_word(8'h40, 4, 0));
    host_rd(A_STAT, d); check("R5 slot A done after retry", d, 32'h1);
  endtask

  task automatic t_status_irq();
    logic [31:0] d;
    host_wr(B_STAT, 32'h9);
    host_rd(B_STAT, d); check("R6 write 1 keeps done, sets ie", d, 32'h9);
    check("R7 irq with done&ie", 32'(irq), 32'd1);
    host_wr(B_STAT, 32'h8);
    host_rd(B_STAT, d); check("R6 clear keeps ie", d, 32'h8);
    check("R7 irq dropped", 32'(irq), 32'd0);
    host_wr(A_STAT, 32'hFFFF_FFFE);
    host_rd(A_STAT, d); check("R6 other bits read zero", d, 32'h8);
    check("R7 irq clear both", 32'(irq), 32'd0);
    host_wr(B_BASE, 32'hDEAD_BEEF);
    host_rd(B_BASE, d); check("R8 data write ignored", d, exp_word(8'h80, 7, 0));
    host_rd(13'h0000, d); check("R8 low region reads 0", d, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    send_frame(2045, 8'h05);
    host_rd(B_STAT, d); check("R9 oversize no done", d, 32'h8);
    host_rd(A_STAT, d); check("R9 slot A unaffected", d, 32'h8);
    send_frame(2044, 8'h33);
    host_rd(B_BASE + 13'h7F8, d);
    check("R9 max frame last word", d, exp_word(8'h33, 2044, 510));
    host_rd(B_STAT, d); check("R9 max frame stored in same slot", d, 32'h9);
    check("R7 irq after max frame", 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_first_two();
    t_drop_retry();
    t_status_irq();
    t_overflow();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule